// File: doc/BRIEF.md
# Packed SIMD Immediate Left Shifter

This execution unit takes one 32-bit instruction word and a 128-bit source vector each cycle. It recognises the shift-left-by-immediate instruction in its scalar and its packed-vector forms. It shifts every lane of the operand left by the same immediate amount and presents the result one clock later, together with the destination register index and a write enable. Lanes are 8, 16, 32 or 64 bits wide.

A single 7-bit immediate, split into a 4-bit high part and a 3-bit low part, sets the lane width, the lane count and the shift amount. The lane width comes from the highest set bit of the high part. The shift is the whole immediate minus that width.

Words that do not belong to this instruction class are flagged as not handled. Reserved encodings are flagged as undefined. In both cases the result is zero and nothing is written. The unit has one register stage. Its latency does not depend on the data.

Top module: `lane_shl_unit`

## Requirements
- R1: A word is claimed only when bits 15:10 equal 010101 and bits 27:23 equal 11110. Any other word sets `out_foreign`, clears `out_we` and gives a zero result.
- R2: The scalar form has bits 31:28 equal 0101. The vector form has bit 31 = 0, bit 29 = 0 and bit 28 = 0, and its bit 30 is the Q bit. Any other value of bits 31:28 is treated as foreign.
- R3: In the vector form the lane width comes from the high immediate (bits 22:19). The pattern 0001 gives 8 bits, 001x gives 16, 01xx gives 32 and 1xxx gives 64.
- R4: The shift amount is the 7-bit value {bits 22:19, bits 18:16} minus the lane width.
- R5: Each lane is shifted on its own with a logical left shift. Bits that leave a lane are dropped and never enter the next lane, and zeros fill from the right.
- R6: A vector word with Q = 1 works on all 128 bits. With Q = 0 it works on bits 63:0, and result bits 127:64 are zero.
- R7: A vector word whose high immediate is 0000 is foreign: `out_foreign` = 1, `out_we` = 0 and the result is zero.
- R8: A vector word with bit 22 = 1 and Q = 0 is undefined: `out_undef` = 1, `out_we` = 0 and the result is zero.
- R9: A scalar word needs bit 22 = 1 and is undefined otherwise. When defined, it shifts one 64-bit lane by the immediate minus 64, and result bits 127:64 are zero.
- R10: `out_valid` equals `in_valid` delayed by exactly one cycle for every word and every operand. `out_rd` carries bits 4:0 of the word.
- R11: During reset and right after it, `out_valid`, `out_we`, `out_undef`, `out_foreign` and `out_result` are all zero.
- R12: `out_we` is high only when `out_valid` is high and the word is claimed and defined. The flags `out_undef` and `out_foreign` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operand present |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector |
| out_valid | output | 1 | Result stage holds an instruction |
| out_result | output | 128 | Shifted vector, zero when not written |
| out_rd | output | 5 | Destination register index |
| out_we | output | 1 | Result should be written |
| out_undef | output | 1 | Encoding is reserved |
| out_foreign | output | 1 | Word belongs to another class |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector and 5-bit register indices. With these values every arrangement can be reached, from sixteen 8-bit lanes to the single scalar lane, and both halves of the vector take part. An all-ones operand shifted by the largest legal amount makes any leak across a lane boundary visible in the result. Back-to-back words with different operands show that the single-cycle latency holds whatever the data.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

  // Decoded view of one instruction word
  typedef struct packed {
    logic       claim;      // word belongs to this class
    logic       undef;      // reserved encoding
    logic       wide;       // full-width operation
    logic [1:0] size_code;  // 0:8 1:16 2:32 3:64
    logic [5:0] shamt;      // shift inside a lane
    logic [4:0] rd;
  } lsh_dec_t;

  // Index of the highest set bit of the high immediate
  function automatic logic [1:0] lsh_size_code(input logic [3:0] hi);
    if (hi[3])      return 2'd3;
    else if (hi[2]) return 2'd2;
    else if (hi[1]) return 2'd1;
    else            return 2'd0;
  endfunction

  // Lane width in bits for a size code
  function automatic logic [6:0] lsh_lane_bits(input logic [1:0] code);
    return 7'd8 << code;
  endfunction

  // Immediate minus lane width
  function automatic logic [5:0] lsh_shift_amt(input logic [3:0] hi,
                                               input logic [2:0] lo,
                                               input logic [1:0] code);
    logic [6:0] diff;
    diff = {hi, lo} - lsh_lane_bits(code);
    return diff[5:0];
  endfunction

endpackage

// File: rtl/lsh_decode.sv
module lsh_decode
  import lsh_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] insn,
  output lsh_dec_t          dec
);

  localparam logic [5:0] OPC_LO = 6'b010101;
  localparam logic [4:0] OPC_HI = 5'b11110;

  logic [3:0] imm_hi;
  logic [2:0] imm_lo;
  logic       q_bit;
  logic       field_hit;
  logic       form_scalar;
  logic       form_vector;
  logic       hi_zero;
  logic [1:0] code;
  logic       unused_rn;

  assign imm_hi      = insn[22:19];
  assign imm_lo      = insn[18:16];
  assign q_bit       = insn[30];
  assign field_hit   = (insn[15:10] == OPC_LO) && (insn[27:23] == OPC_HI);
  assign form_scalar = (insn[31:28] == 4'b0101);
  assign form_vector = !insn[31] && (insn[29:28] == 2'b00);
  assign hi_zero     = (imm_hi == 4'b0000);
  assign unused_rn   = ^insn[9:5];

  // scalar always uses the 64-bit lane
  assign code = form_scalar ? 2'd3 : lsh_size_code(imm_hi);

  always_comb begin
    dec           = '0;
    dec.rd        = insn[REG_W-1:0];
    dec.size_code = code;
    dec.shamt     = lsh_shift_amt(imm_hi, imm_lo, code);
    dec.wide      = form_vector && q_bit;
    if (field_hit && form_scalar) begin
      dec.claim = 1'b1;
      dec.undef = !imm_hi[3];
    end else if (field_hit && form_vector && !hi_zero) begin
      dec.claim = 1'b1;
      dec.undef = imm_hi[3] && !q_bit;
    end
  end

  // R4: a defined word never shifts by a lane width or more
  always_ff @(posedge clk) begin
    if (rst_n && dec.claim && !dec.undef)
      a_r4_shift_in_lane: assert ({1'b0, dec.shamt} < lsh_lane_bits(dec.size_code))
        else $error("shift exceeds lane width");
  end

  // R3: vector 8-bit lanes only from high immediate 0001
  always_ff @(posedge clk) begin
    if (rst_n && dec.claim && form_vector && dec.size_code == 2'd0)
      a_r3_byte_lane: assert (imm_hi == 4'b0001)
        else $error("byte lane from wrong immediate");
  end

endmodule

// File: rtl/lsh_lane_shift.sv
module lsh_lane_shift
  import lsh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] src,
  input  logic [1:0]       size_code,
  input  logic [5:0]       shamt,
  input  logic             wide,
  output logic [VEC_W-1:0] shifted
);

  localparam int N_SIZES = 4;
  localparam int HALF_W  = VEC_W / 2;

  logic [VEC_W-1:0] by_size [N_SIZES];
  logic [VEC_W-1:0] picked;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int LW  = 8 << s;
    localparam int NL  = VEC_W / LW;
    localparam int SHW = $clog2(LW);
    logic [SHW-1:0] sh;
    assign sh = shamt[SHW-1:0];
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign by_size[s][l*LW +: LW] = src[l*LW +: LW] << sh;
    end
  end

  assign picked = by_size[size_code];

  // narrow forms leave the upper half clear
  assign shifted = wide ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};

endmodule

// File: rtl/lsh_out_stage.sv
module lsh_out_stage
  import lsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  lsh_dec_t         dec,
  input  logic [VEC_W-1:0] shifted,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result,
  output logic [REG_W-1:0] out_rd,
  output logic             out_we,
  output logic             out_undef,
  output logic             out_foreign
);

  logic do_write;
  logic flag_undef;
  logic flag_foreign;

  assign do_write     = in_valid && dec.claim && !dec.undef;
  assign flag_undef   = in_valid && dec.claim && dec.undef;
  assign flag_foreign = in_valid && !dec.claim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
      out_we      <= 1'b0;
      out_undef   <= 1'b0;
      out_foreign <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_result  <= do_write ? shifted : '0;
      out_rd      <= dec.rd;
      out_we      <= do_write;
      out_undef   <= flag_undef;
      out_foreign <= flag_foreign;
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r12_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_valid && !out_undef && !out_foreign));

  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_undef && out_foreign));

  a_r12_flag_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_undef || out_foreign) |-> (out_result == '0));

endmodule

// File: rtl/lane_shl_unit.sv
module lane_shl_unit
  import lsh_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int REG_W  = 5,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [VEC_W-1:0]  in_src,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_result,
  output logic [REG_W-1:0]  out_rd,
  output logic              out_we,
  output logic              out_undef,
  output logic              out_foreign
);

  localparam int HALF_W = VEC_W / 2;

  lsh_dec_t         dec;
  logic [VEC_W-1:0] shifted;

  lsh_decode #(.INSN_W(INSN_W), .REG_W(REG_W)) u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .insn  (in_insn),
    .dec   (dec)
  );

  lsh_lane_shift #(.VEC_W(VEC_W)) u_shift (
    .src       (in_src),
    .size_code (dec.size_code),
    .shamt     (dec.shamt),
    .wide      (dec.wide),
    .shifted   (shifted)
  );

  lsh_out_stage #(.VEC_W(VEC_W), .REG_W(REG_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .dec         (dec),
    .shifted     (shifted),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_rd      (out_rd),
    .out_we      (out_we),
    .out_undef   (out_undef),
    .out_foreign (out_foreign)
  );

  // R6: narrow operations leave the upper half of the result clear
  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec.wide) |=> (out_result[VEC_W-1:HALF_W] == '0));

  // R10: destination index carried through the stage
  a_r10_rd_carried: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_rd == $past(in_insn[REG_W-1:0])));

endmodule

// File: tb/lane_shl_unit_bench.sv
module lane_shl_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_src = '0;
  logic         out_valid;
  logic [127:0] out_result;
  logic [4:0]   out_rd;
  logic         out_we;
  logic         out_undef;
  logic         out_foreign;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_shl_unit u_lane_shl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_src(in_src), .out_valid(out_valid), .out_result(out_result),
    .out_rd(out_rd), .out_we(out_we), .out_undef(out_undef),
    .out_foreign(out_foreign)
  );

  localparam logic [127:0] PAT_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] PAT_B = 128'h8000_0001_F0F0_0F0F_A5A5_5A5A_C3C3_3C3C;
  localparam logic [127:0] ONES  = {128{1'b1}};

  // vector word from lane width and shift (immediate = width + shift)
  function automatic logic [31:0] vec_word(bit q, int w, int s, logic [4:0] rd);
    logic [6:0] imm;
    imm = 7'(w + s);
    return {1'b0, q, 2'b00, 5'b11110, imm, 6'b010101, 5'd7, rd};
  endfunction

  function automatic logic [31:0] sca_word(int s, logic [4:0] rd);
    logic [6:0] imm;
    imm = 7'(64 + s);
    return {4'b0101, 5'b11110, imm, 6'b010101, 5'd3, rd};
  endfunction

  // bitwise reference: each bit comes from s places lower in the same lane
  function automatic logic [127:0] ref_shl(logic [127:0] src, int w, int s, bit wide);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 128; i++) begin
      if (wide || i < 64) begin
        if ((i % w) >= s) r[i] = src[i - s];
      end
    end
    return r;
  endfunction

  task automatic check_out(string req, logic [127:0] er, logic [4:0] erd,
                           bit ewe, bit eun, bit efo);
    checks++;
    if (out_valid !== 1'b1 || out_result !== er || out_we !== ewe ||
        out_undef !== eun || out_foreign !== efo || out_rd !== erd) begin
      failures++;
      $display("FAIL %s: got v=%b res=%h rd=%0d we=%b un=%b fo=%b exp v=1 res=%h rd=%0d we=%b un=%b fo=%b",
               req, out_valid, out_result, out_rd, out_we, out_undef, out_foreign,
               er, erd, ewe, eun, efo);
    end
  endtask

  task automatic run_one(string req, logic [31:0] w, logic [127:0] src,
                         logic [127:0] er, bit ewe, bit eun, bit efo);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_src = src;
    @(negedge clk);
    in_valid = 1'b0; in_insn = '0; in_src = '0;
    check_out(req, er, w[4:0], ewe, eun, efo);
  endtask

  task automatic test_reset();
    checks++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_undef !== 1'b0 ||
        out_foreign !== 1'b0 || out_result !== '0) begin
      failures++;
      $display("FAIL R11: got v=%b we=%b un=%b fo=%b res=%h exp all zero",
               out_valid, out_we, out_undef, out_foreign, out_result);
    end
  endtask

  task automatic test_arrangements();
    // R3 R4 R6 across every lane width and both Q values
    run_one("R3 8b q1", vec_word(1, 8, 3, 5'd1), PAT_A, ref_shl(PAT_A, 8, 3, 1), 1, 0, 0);
    run_one("R6 8b q0", vec_word(0, 8, 1, 5'd2), PAT_A, ref_shl(PAT_A, 8, 1, 0), 1, 0, 0);
    run_one("R3 16b q1", vec_word(1, 16, 9, 5'd3), PAT_B, ref_shl(PAT_B, 16, 9, 1), 1, 0, 0);
    run_one("R6 16b q0", vec_word(0, 16, 4, 5'd4), PAT_B, ref_shl(PAT_B, 16, 4, 0), 1, 0, 0);
    run_one("R3 32b q1", vec_word(1, 32, 17, 5'd5), PAT_A, ref_shl(PAT_A, 32, 17, 1), 1, 0, 0);
    run_one("R6 32b q0", vec_word(0, 32, 30, 5'd6), PAT_B, ref_shl(PAT_B, 32, 30, 0), 1, 0, 0);
    run_one("R3 64b q1", vec_word(1, 64, 40, 5'd31), PAT_A, ref_shl(PAT_A, 64, 40, 1), 1, 0, 0);
    run_one("R4 shift zero", vec_word(1, 16, 0, 5'd8), PAT_B, PAT_B, 1, 0, 0);
  endtask

  task automatic test_lane_isolation();
    // R5: largest shift on all ones leaves only the top bit of each lane
    run_one("R5 8b max", vec_word(1, 8, 7, 5'd9), ONES, {16{8'h80}}, 1, 0, 0);
    run_one("R5 32b max", vec_word(1, 32, 31, 5'd10), ONES, {4{32'h8000_0000}}, 1, 0, 0);
    run_one("R5 64b max", vec_word(1, 64, 63, 5'd11), ONES, {2{64'h8000_0000_0000_0000}}, 1, 0, 0);
  endtask

  task automatic test_scalar();
    run_one("R9 scalar", sca_word(12, 5'd12), PAT_A, ref_shl(PAT_A, 64, 12, 0), 1, 0, 0);
    run_one("R9 scalar zero", sca_word(0, 5'd13), PAT_B, {64'h0, PAT_B[63:0]}, 1, 0, 0);
    // R9: high immediate bit 3 clear -> undefined
    run_one("R9 scalar undef", {4'b0101, 5'b11110, 4'b0111, 3'b010, 6'b010101, 5'd0, 5'd14},
            ONES, '0, 0, 1, 0);
  endtask

  task automatic test_rejects();
    // R8: 64-bit lanes with Q = 0
    run_one("R8 vec undef", vec_word(0, 64, 5, 5'd15), ONES, '0, 0, 1, 0);
    // R7: high immediate zero
    run_one("R7 hi zero", {1'b0, 1'b1, 2'b00, 5'b11110, 4'b0000, 3'b101, 6'b010101, 5'd0, 5'd16},
            ONES, '0, 0, 0, 1);
    // R1: low opcode field wrong
    run_one("R1 opcode", {1'b0, 1'b1, 2'b00, 5'b11110, 4'b0001, 3'b001, 6'b010111, 5'd0, 5'd17},
            ONES, '0, 0, 0, 1);
    run_one("R1 high field", {1'b0, 1'b1, 2'b00, 5'b11111, 4'b0001, 3'b001, 6'b010101, 5'd0, 5'd18},
            ONES, '0, 0, 0, 1);
    // R2: bits 31:28 neither scalar nor vector form
    run_one("R2 form", {4'b0110, 5'b11110, 4'b1000, 3'b001, 6'b010101, 5'd0, 5'd19},
            ONES, '0, 0, 0, 1);
  endtask

  task automatic test_back_to_back();
    // R10: consecutive words with different data, each one cycle later
    @(negedge clk);
    in_valid = 1'b1; in_insn = vec_word(1, 8, 2, 5'd20); in_src = PAT_A;
    @(negedge clk);
    check_out("R10 first", ref_shl(PAT_A, 8, 2, 1), 5'd20, 1, 0, 0);
    in_insn = vec_word(1, 8, 2, 5'd21); in_src = ONES;
    @(negedge clk);
    check_out("R10 second", ref_shl(ONES, 8, 2, 1), 5'd21, 1, 0, 0);
    in_insn = sca_word(5, 5'd22); in_src = '0;
    @(negedge clk);
    check_out("R10 third", '0, 5'd22, 1, 0, 0);
    in_valid = 1'b0; in_insn = '0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_we !== 1'b0) begin
      failures++;
      $display("FAIL R10 idle: got v=%b we=%b exp v=0 we=0", out_valid, out_we);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_arrangements();
    test_lane_isolation();
    test_scalar();
    test_rejects();
    test_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule